// File: doc/BRIEF.md
# Cache Profiling Event Counters

This block keeps eight 32-bit event counters that show how well a code cache works. Every lookup the cache finishes is reported as a one-cycle event pulse. The pulse carries three tags: the memory region it targeted (on-chip flash or execute-in-place external memory), the access kind (instruction fetch or data load), and whether it hit or missed. The pulse advances exactly one counter, the one that matches its three tags. So the counters form a region × kind × outcome matrix.

A level input gates counting globally. A clear strobe zeroes all eight counters in one cycle, and it may arrive at any moment. Software reads the counters through a plain combinational read port that takes a byte address. Each region has a fixed block of four words. The block for region n starts at 0x400 + n × 0x20.

Top module: `cache_prof_counters`

## Requirements
- R1: Counter addresses: region n (0 = flash, 1 = XIP) places instruction hits at 0x400 + n×0x20, instruction misses at +0x04, data hits at +0x08 and data misses at +0x0C. `rd_data` returns the addressed counter, zero-extended to 32 bits, in the same cycle.
- R2: After a synchronous active-low reset, all eight counters read 0.
- R3: When `prof_en` is 1 and `evt_valid` is 1, exactly one counter increments by one at the next rising edge. The counter is chosen by `evt_region`, `evt_kind` (0 = instruction, 1 = data) and `evt_hit` (1 = hit, 0 = miss). All other counters keep their values.
- R4: When `prof_en` is 0, event pulses change no counter.
- R5: A cycle with `prof_clr` at 1 sets all eight counters to 0 at the next edge, whatever `prof_en` is. Counting resumes with the next event.
- R6: If an event and `prof_clr` arrive in the same cycle, the clear wins and the event is not counted.
- R7: A counter at its all-ones value that receives an event wraps to 0 and raises no flag.
- R8: Any read address that does not name one of the eight counters returns 0. This includes misaligned addresses and the gap between region blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prof_en | input | 1 | Global counting enable level |
| prof_clr | input | 1 | Clear-all strobe, one cycle |
| evt_valid | input | 1 | Lookup-completed event pulse |
| evt_region | input | 1 | Region of the event: 0 flash, 1 XIP |
| evt_kind | input | 1 | Access kind: 0 instruction, 1 data |
| evt_hit | input | 1 | Outcome: 1 hit, 0 miss |
| rd_addr | input | 12 | Byte address of the register read |
| rd_data | output | 32 | Read-back value of the addressed counter |

## Verification
The hardest case to reach from the ports is the wrap from all-ones to zero. A 32-bit counter would need four billion events to get there. The bench therefore runs a second instance with 4-bit counters, fed in parallel from the same inputs, and checks its read-back against the reference count modulo 16 after seventeen events to one counter. The clear-versus-event collision is driven by a single task that raises both strobes in the same cycle. Each counter is first given a distinct count, so a wrong address decode shows up as a swapped value.

// File: rtl/prof_pkg.sv
// Shared constants and helpers for the profiling counter bank.
// Assumes four counters per region, ordered instr-hit, instr-miss, data-hit, data-miss.
package prof_pkg;
    localparam int unsigned SLOTS_PER_REGION = 4;
    localparam int unsigned SLOT_BYTES       = 4;

    typedef enum logic {
        KIND_INSTR = 1'b0,
        KIND_DATA  = 1'b1
    } acc_kind_e;

    // Flat index of a counter from its region, kind and outcome.
    function automatic int unsigned slot_index(input int unsigned region,
                                               input logic kind,
                                               input logic hit);
        return region * SLOTS_PER_REGION + (kind ? 2 : 0) + (hit ? 0 : 1);
    endfunction
endpackage

// File: rtl/prof_evt_sel.sv
// Turns one tagged event into a one-hot increment vector for the counter bank.
// Assumes at most one event per cycle. A clear or a low enable suppresses every increment.
module prof_evt_sel
    import prof_pkg::*;
#(
    parameter int unsigned N_REGION = 2,
    parameter int unsigned REG_W    = 1,
    localparam int unsigned N_CNT   = N_REGION * SLOTS_PER_REGION
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             valid,
    input  logic [REG_W-1:0] region,
    input  logic             kind,
    input  logic             hit,
    output logic [N_CNT-1:0] sel
);
    // Decode: raise the single slot matching the event tags when counting is allowed.
    always_comb begin
        sel = '0;
        if (en && valid && !clr && (int'(region) < N_REGION))
            sel[slot_index(int'(region), kind, hit)] = 1'b1;
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R3
    AST_SEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !valid) |-> (sel == '0)); // R4
    AST_SEL_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (sel == '0)); // R6
endmodule

// File: rtl/prof_cnt.sv
// One wrapping event counter with a synchronous clear that has priority over increment.
// Assumes inc is already gated by enable and clear.
module prof_cnt #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    // Count register: reset or clear to zero, else step by one on inc (wraps naturally).
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (inc)  cnt <= cnt + 1'b1;
    end

    AST_CNT_RESET: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt == $past(cnt) + 1'b1)); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt)); // R4
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R5
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && (&cnt)) |=> (cnt == '0)); // R7
endmodule

// File: rtl/prof_rd_mux.sv
// Address decode and read-back for the counter bank; purely combinational.
// Assumes word-aligned slots at BASE + region*STRIDE + slot*4; any other address reads zero.
module prof_rd_mux
    import prof_pkg::*;
#(
    parameter int unsigned N_REGION = 2,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned BASE     = 'h400,
    parameter int unsigned STRIDE   = 'h20,
    localparam int unsigned N_CNT   = N_REGION * SLOTS_PER_REGION
) (
    input  logic [N_CNT*CNT_W-1:0] cnt_flat,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_data
);
    logic [N_CNT-1:0] hit_vec;

    // Per-slot address comparators, one per counter.
    for (genvar i = 0; i < N_CNT; i++) begin : g_cmp
        localparam int unsigned SLOT_ADDR =
            BASE + (i / SLOTS_PER_REGION) * STRIDE + (i % SLOTS_PER_REGION) * SLOT_BYTES;
        assign hit_vec[i] = (rd_addr == ADDR_W'(SLOT_ADDR));
    end

    // Read mux: OR in the matching counter, zero-extended; nothing matches gives zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_CNT; i++)
            if (hit_vec[i]) rd_data = rd_data | DATA_W'(cnt_flat[i*CNT_W +: CNT_W]);
    end

    AST_ADDR_UNIQUE: assert final ($onehot0(hit_vec)); // R1
endmodule

// File: rtl/cache_prof_counters.sv
// Profiling counter bank: per-region, per-kind hit and miss counters with global enable,
// clear-all and a combinational read port. Assumes one event per cycle at most.
module cache_prof_counters
    import prof_pkg::*;
#(
    parameter int unsigned N_REGION = 2,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned BASE     = 'h400,
    parameter int unsigned STRIDE   = 'h20,
    localparam int unsigned REG_W   = (N_REGION > 1) ? $clog2(N_REGION) : 1,
    localparam int unsigned N_CNT   = N_REGION * SLOTS_PER_REGION
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prof_en,
    input  logic              prof_clr,
    input  logic              evt_valid,
    input  logic [REG_W-1:0]  evt_region,
    input  logic              evt_kind,
    input  logic              evt_hit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [N_CNT-1:0]       inc_vec;
    logic [N_CNT*CNT_W-1:0] cnt_flat;

    prof_evt_sel #(.N_REGION(N_REGION), .REG_W(REG_W)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (prof_en),
        .clr    (prof_clr),
        .valid  (evt_valid),
        .region (evt_region),
        .kind   (evt_kind),
        .hit    (evt_hit),
        .sel    (inc_vec)
    );

    // Counter array: one instance per region/kind/outcome slot.
    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        prof_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (prof_clr),
            .inc   (inc_vec[i]),
            .cnt   (cnt_flat[i*CNT_W +: CNT_W])
        );
    end

    prof_rd_mux #(
        .N_REGION (N_REGION),
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BASE     (BASE),
        .STRIDE   (STRIDE)
    ) u_rd (
        .cnt_flat (cnt_flat),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!prof_en && !prof_clr) |=> $stable(cnt_flat)); // R4
    AST_BANK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        prof_clr |=> (cnt_flat == '0)); // R6
endmodule

// File: tb/sim_cache_prof_counters.sv
// Scoreboard bench: driver tasks update a reference model and queue expected reads;
// a monitor pops each item and compares both instances' read-back.
module sim_cache_prof_counters;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned WRAP_W     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prof_en = 1'b0, prof_clr = 1'b0, evt_valid = 1'b0;
    logic        evt_region = 1'b0, evt_kind = 1'b0, evt_hit = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data, rd_data_w;

    int unsigned model [8];
    int          n_chk = 0, n_err = 0;
    bit          done = 0;

    logic [31:0] q_exp  [$];
    logic [11:0] q_addr [$];
    string       q_tag  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_prof_counters u0 (
        .clk(clk), .rst_n(rst_n), .prof_en(prof_en), .prof_clr(prof_clr),
        .evt_valid(evt_valid), .evt_region(evt_region), .evt_kind(evt_kind),
        .evt_hit(evt_hit), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    cache_prof_counters #(.CNT_W(WRAP_W)) u_wrap (
        .clk(clk), .rst_n(rst_n), .prof_en(prof_en), .prof_clr(prof_clr),
        .evt_valid(evt_valid), .evt_region(evt_region), .evt_kind(evt_kind),
        .evt_hit(evt_hit), .rd_addr(rd_addr), .rd_data(rd_data_w)
    );

    function automatic logic [11:0] slot_addr(input int idx);
        return 12'(32'h400 + (idx / 4) * 32'h20 + (idx % 4) * 4);
    endfunction

    // Driver: one event (optionally with clear) in one cycle; model follows the requirements.
    task automatic pulse(input int idx, input bit with_clr);
        @(negedge clk);
        evt_valid  = 1'b1;
        evt_region = idx[2];
        evt_kind   = idx[1];
        evt_hit    = ~idx[0];
        prof_clr   = with_clr;
        if (with_clr) foreach (model[i]) model[i] = 0;
        else if (prof_en) model[idx] = model[idx] + 1;
        @(negedge clk);
        evt_valid = 1'b0;
        prof_clr  = 1'b0;
    endtask

    task automatic clear_only();
        @(negedge clk);
        prof_clr = 1'b1;
        foreach (model[i]) model[i] = 0;
        @(negedge clk);
        prof_clr = 1'b0;
    endtask

    // Driver: set the read address and queue what both instances must return.
    task automatic chk(input logic [11:0] addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_addr = addr;
        q_addr.push_back(addr);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic chk_all(input string tag);
        for (int i = 0; i < 8; i++) chk(slot_addr(i), model[i], tag);
    endtask

    // Monitor: sample read data away from the edge and compare with the queued item.
    always @(negedge clk) begin
        #2;
        if (q_exp.size() > 0) begin
            automatic logic [31:0] e  = q_exp.pop_front();
            automatic logic [11:0] a  = q_addr.pop_front();
            automatic string       t  = q_tag.pop_front();
            automatic logic [31:0] ew = e & ((32'd1 << WRAP_W) - 1);
            n_chk += 2;
            if (rd_data !== e) begin
                n_err++;
                $display("FAIL %s addr=%h actual=%h expected=%h", t, a, rd_data, e);
            end
            if (rd_data_w !== ew) begin
                n_err++;
                $display("FAIL %s narrow addr=%h actual=%h expected=%h", t, a, rd_data_w, ew);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        foreach (model[i]) model[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_all("R2");
        // R8: unmapped and misaligned addresses read zero
        chk(12'h3FC, 0, "R8"); chk(12'h402, 0, "R8"); chk(12'h410, 0, "R8");
        chk(12'h41C, 0, "R8"); chk(12'h430, 0, "R8"); chk(12'h000, 0, "R8");
        // R4: events while disabled are ignored
        pulse(0, 0); pulse(5, 0); pulse(7, 0);
        chk_all("R4");
        // R3: mixed pattern, enable on
        prof_en = 1'b1;
        pulse(0, 0); pulse(0, 0); pulse(3, 0); pulse(6, 0); pulse(0, 0);
        chk_all("R3");
        clear_only();
        // R1: distinct count per slot exposes any address swap
        for (int i = 0; i < 8; i++) for (int j = 0; j <= i; j++) pulse(i, 0);
        chk_all("R1");
        chk(12'h42C, 8, "R1"); chk(12'h400, 1, "R1");
        // R8 again with nonzero counters
        chk(12'h418, 0, "R8"); chk(12'h440, 0, "R8");
        // R4: disable again with live counts
        prof_en = 1'b0;
        pulse(2, 0); pulse(4, 0);
        chk_all("R4");
        // R5: clear while disabled
        clear_only();
        chk_all("R5");
        prof_en = 1'b1;
        pulse(1, 0);
        chk_all("R5");
        // R6: clear and event in the same cycle
        pulse(2, 0); pulse(2, 0);
        pulse(6, 1);
        chk_all("R6");
        // R7: seventeen events to one slot, narrow instance wraps to 1
        for (int j = 0; j < 17; j++) pulse(5, 0);
        chk_all("R7");
        chk(slot_addr(5), 17, "R7");
        @(negedge clk); @(negedge clk);
        wait (q_exp.size() == 0);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule